// File: doc/BRIEF.md
# Two-Bank DRAM Command Timing Monitor

This block sits beside the command pins of a two-bank synchronous DRAM and judges every command the controller issues. At each rising clock edge it decodes chip select, row strobe, column strobe, write enable, the bank select bit and address bit 10. It tracks whether each bank has an open row, and it keeps saturating clock-age counters for the last activate, precharge, read and write of each bank, plus the last mode set and auto refresh. When a command breaks a timing or state rule, a sticky violation flag rises with a 4-bit code that names the broken rule. The flag and code hold until the clear input is pulsed.

All minimum delays are parameters in clock cycles. Each one is a nanosecond limit divided by the clock period and rounded up. The defaults suit a 5 ns clock with CAS latency 3 and burst length 4. The monitor checks command ordering only. It models no storage, no data values and no electrical timing. It has no data stream, so every pin is plain control or status.

The gap between two commands is counted in clock edges. A command at edge t and one at edge t+k have a gap of k. A rule "at least N" passes when k >= N.

Top module: `dram_cmd_monitor`

## Requirements
- R1: After reset, `viol_flag` is 0, `viol_code` is 0 and `bank_open` is 2'b00.
- R2: Commands are decoded from {cs_n,ras_n,cas_n,we_n} as follows: 0000 mode set, 0001 auto refresh, 0011 activate, 0101 read, 0100 write, 0110 burst stop, 0010 precharge, 0111 no-op, and cs_n=1 deselect. `ba`=0 selects bank A, which is `bank_open[0]`, and `ba`=1 selects bank B, which is `bank_open[1]`. An activate opens the selected bank. A precharge closes it. A precharge with `a10`=1 closes both banks and ignores `ba`.
- R3: An activate to a bank that is already open gives code 1. A read or write to an idle bank gives code 2.
- R4: A read or write less than TRCD clocks after the activate of its bank gives code 3.
- R5: An activate less than TRP clocks after that bank was closed gives code 4. An activate less than TRC clocks after that bank's previous activate gives code 6.
- R6: A precharge of an open bank less than TRAS clocks after its activate gives code 5.
- R7: An activate less than TRRD clocks after an activate of the other bank gives code 7.
- R8: A precharge of an open bank less than BURST_LEN-1+TWR clocks after a write to it gives code 8. With the defaults this limit is 5.
- R9: A precharge of an open bank less than CAS_LAT+BURST_LEN-2 clocks after a read of it gives code 9. With the defaults this limit is 5.
- R10: A mode set or auto refresh while either bank is open gives code 10.
- R11: Any command other than no-op or deselect less than TMRD clocks after a mode set gives code 11. Any such command less than TRFC clocks after an auto refresh gives code 12.
- R12: A read or write with `a10`=1 closes its bank BURST_LEN clocks after the command. A read or write to that bank before the close gives code 13.
- R13: The first violation is latched and holds through later violations until `clr` is pulsed. When one command breaks several rules, the smallest code is reported. A violation in the same cycle as `clr` is latched in place of the old one.
- R14: Reads and writes to an open bank may follow one another on every clock without a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select (0 = bank A, 1 = bank B) |
| a10 | input | 1 | All-bank precharge, or auto precharge on a read or write |
| clr | input | 1 | Clears the latched violation |
| viol_flag | output | 1 | Sticky violation indicator |
| viol_code | output | 4 | Code of the latched violation, 0 when none |
| bank_open | output | 2 | Open state per bank, bit 0 = bank A |

## Verification
The directed tests place commands exactly on each limit and one clock short of it. A design with an off-by-one age counter passes one of the two cases and fails the other. An activate that breaks both tRP and tRC must report code 4. An encoder that scans in the wrong direction would report 6. The all-bank precharge is sent with `ba`=1, so a design that honours `ba` leaves bank A open. The auto-precharge test reads `bank_open` one cycle before and one cycle after the internal close, which catches a close that comes early or late. A second violation is sent after the first, and a design that is not sticky would replace code 7 with code 3.

// File: rtl/dram_mon_pkg.sv
package dram_mon_pkg;

  localparam int NUM_BANKS = 2;

  typedef enum logic [3:0] {
    CMD_NOP, CMD_DESEL, CMD_MODE, CMD_REFR, CMD_ACT,
    CMD_RD, CMD_WR, CMD_BST, CMD_PRE
  } cmd_e;

  localparam int VC_ACT_OPEN = 1;
  localparam int VC_COL_IDLE = 2;
  localparam int VC_RCD      = 3;
  localparam int VC_RP       = 4;
  localparam int VC_RAS      = 5;
  localparam int VC_RC       = 6;
  localparam int VC_RRD      = 7;
  localparam int VC_WR_REC   = 8;
  localparam int VC_RD_PRE   = 9;
  localparam int VC_BUSY     = 10;
  localparam int VC_MRD      = 11;
  localparam int VC_RFC      = 12;
  localparam int VC_AP_COL   = 13;
  localparam int VC_TOP      = 15;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
  import dram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MODE;
        3'b001:  cmd = CMD_REFR;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/dram_age_ctr.sv
module dram_age_ctr #(
  parameter int CW  = 4,
  parameter int LIM = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] age
);
  localparam logic [CW-1:0] AGE_MAX = CW'(LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age <= AGE_MAX;
    end else if (restart) begin
      age <= CW'(1);
    end else if (age != AGE_MAX) begin
      age <= age + CW'(1);
    end
  end
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker #(
  parameter int CW        = 4,
  parameter int LIM       = 15,
  parameter int BURST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_act,
  input  logic          do_rd,
  input  logic          do_wr,
  input  logic          do_ap,
  input  logic          do_pre,
  output logic          is_open,
  output logic          ap_busy,
  output logic [CW-1:0] age_act,
  output logic [CW-1:0] age_pre,
  output logic [CW-1:0] age_rd,
  output logic [CW-1:0] age_wr
);
  localparam logic [CW-1:0] AP_END = CW'(BURST_LEN);

  logic          ap_run;
  logic [CW-1:0] ap_cnt;
  logic          ap_close;
  logic          close_evt;
  logic          ap_start;

  assign ap_close  = ap_run && (ap_cnt == AP_END);
  assign close_evt = (do_pre && is_open) || ap_close;
  assign ap_start  = (do_rd || do_wr) && do_ap && is_open;
  assign ap_busy   = ap_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
    end else if (do_act) begin
      is_open <= 1'b1;
    end else if (close_evt) begin
      is_open <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ap_run <= 1'b0;
      ap_cnt <= '0;
    end else if (ap_start) begin
      ap_run <= 1'b1;
      ap_cnt <= CW'(1);
    end else if (do_pre || ap_close) begin
      ap_run <= 1'b0;
      ap_cnt <= '0;
    end else if (ap_run) begin
      ap_cnt <= ap_cnt + CW'(1);
    end
  end

  dram_age_ctr #(.CW(CW), .LIM(LIM)) u_age_act (
    .clk(clk), .rst_n(rst_n), .restart(do_act), .age(age_act));
  dram_age_ctr #(.CW(CW), .LIM(LIM)) u_age_pre (
    .clk(clk), .rst_n(rst_n), .restart(close_evt), .age(age_pre));
  dram_age_ctr #(.CW(CW), .LIM(LIM)) u_age_rd (
    .clk(clk), .rst_n(rst_n), .restart(do_rd), .age(age_rd));
  dram_age_ctr #(.CW(CW), .LIM(LIM)) u_age_wr (
    .clk(clk), .rst_n(rst_n), .restart(do_wr), .age(age_wr));
endmodule

// File: rtl/dram_rule_check.sv
module dram_rule_check
  import dram_mon_pkg::*;
#(
  parameter int CW        = 4,
  parameter int TRCD      = 3,
  parameter int TRP       = 3,
  parameter int TRAS      = 8,
  parameter int TRC       = 11,
  parameter int TRRD      = 2,
  parameter int TMRD      = 2,
  parameter int TRFC      = 11,
  parameter int WR_TO_PRE = 5,
  parameter int RD_TO_PRE = 5
) (
  input  cmd_e                           cmd,
  input  logic                           ba,
  input  logic                           a10,
  input  logic [NUM_BANKS-1:0]           is_open,
  input  logic [NUM_BANKS-1:0]           ap_busy,
  input  logic [NUM_BANKS-1:0][CW-1:0]   age_act,
  input  logic [NUM_BANKS-1:0][CW-1:0]   age_pre,
  input  logic [NUM_BANKS-1:0][CW-1:0]   age_rd,
  input  logic [NUM_BANKS-1:0][CW-1:0]   age_wr,
  input  logic [CW-1:0]                  age_mode,
  input  logic [CW-1:0]                  age_refr,
  output logic [3:0]                     code_now
);
  localparam logic [CW-1:0] K_RCD  = CW'(TRCD);
  localparam logic [CW-1:0] K_RP   = CW'(TRP);
  localparam logic [CW-1:0] K_RAS  = CW'(TRAS);
  localparam logic [CW-1:0] K_RC   = CW'(TRC);
  localparam logic [CW-1:0] K_RRD  = CW'(TRRD);
  localparam logic [CW-1:0] K_MRD  = CW'(TMRD);
  localparam logic [CW-1:0] K_RFC  = CW'(TRFC);
  localparam logic [CW-1:0] K_WPRE = CW'(WR_TO_PRE);
  localparam logic [CW-1:0] K_RPRE = CW'(RD_TO_PRE);

  logic [VC_TOP:0] hit;
  logic            other;
  logic            real_cmd;

  assign other    = ~ba;
  assign real_cmd = (cmd != CMD_NOP) && (cmd != CMD_DESEL);

  always_comb begin
    hit = '0;
    unique case (cmd)
      CMD_ACT: begin
        hit[VC_ACT_OPEN] = is_open[ba];
        hit[VC_RP]       = age_pre[ba] < K_RP;
        hit[VC_RC]       = age_act[ba] < K_RC;
        hit[VC_RRD]      = age_act[other] < K_RRD;
      end
      CMD_RD, CMD_WR: begin
        hit[VC_COL_IDLE] = !is_open[ba];
        hit[VC_RCD]      = is_open[ba] && (age_act[ba] < K_RCD);
        hit[VC_AP_COL]   = ap_busy[ba];
      end
      CMD_PRE: begin
        for (int i = 0; i < NUM_BANKS; i++) begin
          if ((a10 || (ba == 1'(i))) && is_open[i]) begin
            hit[VC_RAS]    = hit[VC_RAS]    | (age_act[i] < K_RAS);
            hit[VC_WR_REC] = hit[VC_WR_REC] | (age_wr[i]  < K_WPRE);
            hit[VC_RD_PRE] = hit[VC_RD_PRE] | (age_rd[i]  < K_RPRE);
          end
        end
      end
      CMD_MODE, CMD_REFR: begin
        hit[VC_BUSY] = |is_open;
      end
      default: ;
    endcase
    if (real_cmd) begin
      hit[VC_MRD] = age_mode < K_MRD;
      hit[VC_RFC] = age_refr < K_RFC;
    end
  end

  // lowest set code wins
  always_comb begin
    code_now = '0;
    for (int i = VC_TOP; i >= 1; i--) begin
      if (hit[i]) code_now = 4'(i);
    end
  end
endmodule

// File: rtl/dram_viol_latch.sv
module dram_viol_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [3:0] code_now,
  output logic       viol_flag,
  output logic [3:0] viol_code
);
  logic fresh;
  assign fresh = (code_now != 4'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_flag <= 1'b0;
      viol_code <= 4'd0;
    end else if (clr) begin
      viol_flag <= fresh;
      viol_code <= code_now;
    end else if (!viol_flag && fresh) begin
      viol_flag <= 1'b1;
      viol_code <= code_now;
    end
  end
endmodule

// File: rtl/dram_cmd_monitor.sv
module dram_cmd_monitor
  import dram_mon_pkg::*;
#(
  parameter int TRCD      = 3,
  parameter int TRP       = 3,
  parameter int TRAS      = 8,
  parameter int TRC       = 11,
  parameter int TRRD      = 2,
  parameter int TMRD      = 2,
  parameter int TRFC      = 11,
  parameter int TWR       = 2,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       ba,
  input  logic       a10,
  input  logic       clr,
  output logic       viol_flag,
  output logic [3:0] viol_code,
  output logic [1:0] bank_open
);
  localparam int WR_TO_PRE = BURST_LEN - 1 + TWR;
  localparam int RD_TO_PRE = CAS_LAT + BURST_LEN - 2;
  localparam int LIM = imax(imax(imax(TRC, TRFC), imax(TRAS, TRP)),
                       imax(imax(TRCD, TRRD), imax(imax(TMRD, BURST_LEN),
                       imax(WR_TO_PRE, RD_TO_PRE))));
  localparam int CW = $clog2(LIM + 1);

  cmd_e cmd;

  logic [NUM_BANKS-1:0]         is_open;
  logic [NUM_BANKS-1:0]         ap_busy;
  logic [NUM_BANKS-1:0][CW-1:0] age_act;
  logic [NUM_BANKS-1:0][CW-1:0] age_pre;
  logic [NUM_BANKS-1:0][CW-1:0] age_rd;
  logic [NUM_BANKS-1:0][CW-1:0] age_wr;
  logic [CW-1:0]                age_mode;
  logic [CW-1:0]                age_refr;
  logic [3:0]                   code_now;

  dram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd));

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = (ba == 1'(g));

    dram_bank_tracker #(.CW(CW), .LIM(LIM), .BURST_LEN(BURST_LEN)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .do_act (sel && (cmd == CMD_ACT)),
      .do_rd  (sel && (cmd == CMD_RD)),
      .do_wr  (sel && (cmd == CMD_WR)),
      .do_ap  (a10),
      .do_pre ((cmd == CMD_PRE) && (a10 || sel)),
      .is_open(is_open[g]),
      .ap_busy(ap_busy[g]),
      .age_act(age_act[g]),
      .age_pre(age_pre[g]),
      .age_rd (age_rd[g]),
      .age_wr (age_wr[g])
    );
  end

  dram_age_ctr #(.CW(CW), .LIM(LIM)) u_age_mode (
    .clk(clk), .rst_n(rst_n), .restart(cmd == CMD_MODE), .age(age_mode));
  dram_age_ctr #(.CW(CW), .LIM(LIM)) u_age_refr (
    .clk(clk), .rst_n(rst_n), .restart(cmd == CMD_REFR), .age(age_refr));

  dram_rule_check #(
    .CW(CW), .TRCD(TRCD), .TRP(TRP), .TRAS(TRAS), .TRC(TRC), .TRRD(TRRD),
    .TMRD(TMRD), .TRFC(TRFC), .WR_TO_PRE(WR_TO_PRE), .RD_TO_PRE(RD_TO_PRE)
  ) u_rules (
    .cmd(cmd), .ba(ba), .a10(a10), .is_open(is_open), .ap_busy(ap_busy),
    .age_act(age_act), .age_pre(age_pre), .age_rd(age_rd), .age_wr(age_wr),
    .age_mode(age_mode), .age_refr(age_refr), .code_now(code_now)
  );

  dram_viol_latch u_latch (
    .clk(clk), .rst_n(rst_n), .clr(clr), .code_now(code_now),
    .viol_flag(viol_flag), .viol_code(viol_code));

  assign bank_open = is_open;
endmodule

// File: rtl/dram_mon_chk.sv
module dram_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       ba,
  input logic       a10,
  input logic       clr,
  input logic       viol_flag,
  input logic [3:0] viol_code,
  input logic [1:0] bank_open
);
  logic quiet, is_act, is_pre, is_col, is_busy_cmd;
  assign quiet       = cs_n || (ras_n && cas_n && we_n);
  assign is_act      = !cs_n && !ras_n &&  cas_n &&  we_n;
  assign is_pre      = !cs_n && !ras_n &&  cas_n && !we_n;
  assign is_col      = !cs_n &&  ras_n && !cas_n;
  assign is_busy_cmd = !cs_n && !ras_n && !cas_n;

  // R13
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag && !clr |=> viol_flag && $stable(viol_code));

  // R13
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && quiet |=> !viol_flag && viol_code == 4'd0);

  // R13
  flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag == (viol_code != 4'd0));

  // R2
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre && a10 |=> bank_open == 2'b00);

  // R2
  act_bank_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act && !ba |=> bank_open[0]);

  // R2
  act_bank_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act && ba |=> bank_open[1]);

  // R10
  busy_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_busy_cmd && (bank_open != 2'b00) && !viol_flag && !clr
    |=> viol_code == 4'd10);

  // R3
  col_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_col && (bank_open == 2'b00) && !viol_flag && !clr
    |=> viol_code == 4'd2);
endmodule

bind dram_cmd_monitor dram_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .a10(a10), .clr(clr), .viol_flag(viol_flag),
  .viol_code(viol_code), .bank_open(bank_open));

// File: tb/dram_cmd_monitor_tb.sv
module dram_cmd_monitor_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] P_MODE = 4'b0000;
  localparam logic [3:0] P_REFR = 4'b0001;
  localparam logic [3:0] P_ACT  = 4'b0011;
  localparam logic [3:0] P_RD   = 4'b0101;
  localparam logic [3:0] P_WR   = 4'b0100;
  localparam logic [3:0] P_PRE  = 4'b0010;
  localparam logic [3:0] P_NOP  = 4'b0111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pins = P_NOP;
  logic ba = 1'b0, a10 = 1'b0, clr = 1'b0;
  logic viol_flag;
  logic [3:0] viol_code;
  logic [1:0] bank_open;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cmd_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(pins[3]), .ras_n(pins[2]),
    .cas_n(pins[1]), .we_n(pins[0]), .ba(ba), .a10(a10), .clr(clr),
    .viol_flag(viol_flag), .viol_code(viol_code), .bank_open(bank_open));

  task automatic chk(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_all(input int f, input int c, input int o, input string tag);
    chk(int'(viol_flag), f, {tag, " flag"});
    chk(int'(viol_code), c, {tag, " code"});
    chk(int'(bank_open), o, {tag, " open"});
  endtask

  task automatic do_reset();
    pins = P_NOP; ba = 1'b0; a10 = 1'b0; clr = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive at a falling edge; returns at the next falling edge with no-op
  task automatic issue(input logic [3:0] c, input logic b, input logic a);
    pins = c; ba = b; a10 = a;
    @(negedge clk);
    pins = P_NOP; ba = 1'b0; a10 = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_all(0, 0, 0, "R1 reset");
  endtask

  task automatic t_legal_flow();
    do_reset();
    issue(P_ACT, 0, 0); idle(2);
    issue(P_RD, 0, 0);
    chk_all(0, 0, 1, "R4 read at tRCD");
    idle(4);
    issue(P_PRE, 0, 0);
    chk_all(0, 0, 0, "R9 precharge at read limit");
  endtask

  task automatic t_back_to_back();
    do_reset();
    issue(P_ACT, 1, 0); idle(2);
    issue(P_WR, 1, 0); issue(P_RD, 1, 0); issue(P_WR, 1, 0);
    chk_all(0, 0, 2, "R14 column every clock");
  endtask

  task automatic t_state_rules();
    do_reset();
    issue(P_RD, 0, 0);
    chk_all(1, 2, 0, "R3 read idle bank");
    do_reset();
    issue(P_ACT, 0, 0); idle(10);
    issue(P_ACT, 0, 0);
    chk_all(1, 1, 1, "R3 activate open bank");
  endtask

  task automatic t_rcd();
    do_reset();
    issue(P_ACT, 1, 0); idle(1);
    issue(P_RD, 1, 0);
    chk_all(1, 3, 2, "R4 tRCD short");
  endtask

  task automatic t_rrd();
    do_reset();
    issue(P_ACT, 0, 0);
    issue(P_ACT, 1, 0);
    chk_all(1, 7, 3, "R7 tRRD short");
    do_reset();
    issue(P_ACT, 0, 0); idle(1);
    issue(P_ACT, 1, 0);
    chk_all(0, 0, 3, "R7 tRRD met");
  endtask

  task automatic t_ras();
    do_reset();
    issue(P_ACT, 0, 0); idle(4);
    issue(P_PRE, 0, 0);
    chk_all(1, 5, 0, "R6 tRAS short");
  endtask

  task automatic t_rp_priority();
    do_reset();
    issue(P_ACT, 0, 0); idle(7);
    issue(P_PRE, 0, 0);
    chk_all(0, 0, 0, "R6 tRAS met");
    idle(1);
    issue(P_ACT, 0, 0);
    chk_all(1, 4, 1, "R5 R13 tRP with tRC lowest code");
  endtask

  task automatic t_write_recovery();
    do_reset();
    issue(P_ACT, 0, 0); idle(3);
    issue(P_WR, 0, 0); idle(3);
    issue(P_PRE, 0, 0);
    chk_all(1, 8, 0, "R8 write recovery short");
    do_reset();
    issue(P_ACT, 0, 0); idle(2);
    issue(P_WR, 0, 0); idle(4);
    issue(P_PRE, 0, 0);
    chk_all(0, 0, 0, "R8 write recovery met");
  endtask

  task automatic t_read_precharge();
    do_reset();
    issue(P_ACT, 0, 0); idle(3);
    issue(P_RD, 0, 0); idle(3);
    issue(P_PRE, 0, 0);
    chk_all(1, 9, 0, "R9 read to precharge short");
  endtask

  task automatic t_precharge_all();
    do_reset();
    issue(P_ACT, 0, 0); idle(1);
    issue(P_ACT, 1, 0);
    chk_all(0, 0, 3, "R2 both banks open");
    idle(7);
    issue(P_PRE, 1, 1);
    chk_all(0, 0, 0, "R2 precharge all ignores bank");
  endtask

  task automatic t_mode_refresh();
    do_reset();
    issue(P_ACT, 0, 0); idle(10);
    issue(P_MODE, 0, 0);
    chk_all(1, 10, 1, "R10 mode set with open bank");
    do_reset();
    issue(P_ACT, 1, 0); idle(10);
    issue(P_REFR, 0, 0);
    chk_all(1, 10, 2, "R10 refresh with open bank");
    do_reset();
    issue(P_MODE, 0, 0);
    issue(P_ACT, 0, 0);
    chk_all(1, 11, 1, "R11 command right after mode set");
    do_reset();
    issue(P_MODE, 0, 0); idle(1);
    issue(P_ACT, 0, 0);
    chk_all(0, 0, 1, "R11 mode set gap met");
    do_reset();
    issue(P_REFR, 0, 0); idle(9);
    issue(P_ACT, 0, 0);
    chk_all(1, 12, 1, "R11 refresh gap short");
    do_reset();
    issue(P_REFR, 0, 0); idle(10);
    issue(P_ACT, 0, 0);
    chk_all(0, 0, 1, "R11 refresh gap met");
  endtask

  task automatic t_auto_precharge();
    do_reset();
    issue(P_ACT, 0, 0); idle(3);
    issue(P_RD, 0, 1); idle(1);
    issue(P_RD, 0, 0);
    chk_all(1, 13, 1, "R12 column during auto precharge");
    do_reset();
    issue(P_ACT, 0, 0); idle(3);
    issue(P_RD, 0, 1);
    idle(3);
    chk_all(0, 0, 1, "R12 bank open before burst end");
    idle(1);
    chk_all(0, 0, 0, "R12 bank closed at burst end");
    idle(2);
    issue(P_ACT, 0, 0);
    chk_all(0, 0, 1, "R12 reopen after tRP");
  endtask

  task automatic t_sticky_clear();
    do_reset();
    issue(P_ACT, 0, 0);
    issue(P_ACT, 1, 0);
    chk_all(1, 7, 3, "R13 first violation");
    issue(P_RD, 0, 0);
    chk_all(1, 7, 3, "R13 sticky code");
    pulse_clr();
    chk_all(0, 0, 3, "R13 clear");
  endtask

  initial begin
    t_reset();
    t_legal_flow();
    t_back_to_back();
    t_state_rules();
    t_rcd();
    t_rrd();
    t_ras();
    t_rp_priority();
    t_write_recovery();
    t_read_precharge();
    t_precharge_all();
    t_mode_refresh();
    t_auto_precharge();
    t_sticky_clear();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule